// File: doc/BRIEF.md
# M12 Four-Tributary Bit-Interleaving Multiplexer

This block builds a second-order multiplex frame from four first-order tributary bit streams. Each tributary runs on its own timing. The block fetches tributary bits one at a time through a request line. In the same cycle the tributary answers with a data bit and a valid flag. The block adds the frame overhead: alignment bits, the remote alarm bit and the coded stuff-control bits. Its output is one serial bit for each clock enable, together with a strobe that marks the first bit of every frame.

A frame holds four subframes. Each subframe holds six blocks, and each block is one overhead bit followed by 48 information bits. The information bits cycle through the tributaries in the order 1, 2, 3, 4, and tributaries 2 and 4 are inverted. Each subframe gives one tributary a stuffing opportunity: subframe n serves tributary n. The stuff request and loopback command for tributary n are taken at the head of subframe n. They set the three control bits of that subframe, and they decide whether a stuff bit replaces one information bit in the last block. The elastic stores and the logic that decides when to stuff are outside the block.

Top module: `m12_mux`

## Requirements
- R1: A frame is 1176 bits: 4 subframes of 6 blocks, each block 49 bits. `t2_frame_start` is high together with the first bit of each frame and with no other bit.
- R2: The overhead bit at the head of block 0 is 0, 1, 1 in subframes 1, 2, 3. The head of block 2 is always 0 and the head of block 5 is always 1.
- R3: The head of block 0 in subframe 4 is the inverse of `lof_in`, taken in the cycle that bit is produced.
- R4: Each head bit is followed by 48 information bits taken from tributaries 1, 2, 3, 4 in turn. `trib_req[n-1]` is high only in the enabled cycle in which a bit of tributary n is taken. `trib_data` and `trib_vld` are sampled in that same cycle. No request is issued for head bits.
- R5: Bits from tributaries 2 and 4 (lanes 1 and 3) are sent inverted. Bits from tributaries 1 and 3 are sent unchanged.
- R6: Without loopback, the heads of blocks 1, 3 and 4 of subframe n all carry the stuff flag of tributary n.
- R7: When the stuff flag of tributary n is set, the n-th bit after the block 5 head of subframe n is sent as 0 and raises no request. The other bits of that block are unaffected.
- R8: `stuff_req[n-1]` and `loop_cmd[n-1]` are sampled only on the head bit of subframe n and held for that whole subframe. At all other times they are ignored.
- R9: When the loopback flag of tributary n is set, the head of block 4 of subframe n is the inverse of the heads of blocks 1 and 3.
- R10: If `trib_vld` is low for the requested lane, that information bit is taken as 1 before any inversion.
- R11: In a cycle with `bit_en` low the position does not advance, no request is raised, `t2_bit` holds, and `t2_strobe` is low in the next cycle. Each enabled cycle produces exactly one new bit, with `t2_strobe` high in the next cycle.
- R12: After reset the outputs are 0, the stuff and loopback flags are clear, and the first enabled bit is the first bit of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Produce one output bit in this cycle |
| lof_in | input | 1 | Local receiver reports loss of frame |
| stuff_req | input | NUM_TRIB | Stuff request, bit n-1 for tributary n |
| loop_cmd | input | NUM_TRIB | Loopback command, bit n-1 for tributary n |
| trib_data | input | NUM_TRIB | Tributary data bit, answered in the request cycle |
| trib_vld | input | NUM_TRIB | Tributary data valid, answered in the request cycle |
| trib_req | output | NUM_TRIB | One-hot request for a tributary bit |
| t2_bit | output | 1 | Serial multiplexed output bit |
| t2_frame_start | output | 1 | Marks the first bit of a frame |
| t2_strobe | output | 1 | A new output bit is present |

## Verification
The bench runs four frames, each with a different stuffing and loopback plan. One frame has no stuffing at all, one stuffs every tributary, and two use mixed patterns with loopback on selected subframes. These patterns show whether the control bits and the stuff-bit position follow the right tributary in each subframe. They also separate the loopback code from a plain stuff code. The stuff and loopback inputs are held inverted outside the subframe heads, so sampling at the wrong time shows up at once. Random tributary data distinguishes the inverted lanes from the plain ones. A frame with periodic invalid data and bursts of idle enables checks the fill value and the hold behaviour. The alarm input is raised in one frame to test the X bit.

// File: rtl/m12_pkg.sv
package m12_pkg;
    // Blocks per subframe; the overhead slot order below is fixed by the frame format.
    localparam int BLOCKS_PER_SF = 6;
    localparam int BLK_W         = 3;

    // Meaning of the head bit of each block within a subframe.
    typedef enum logic [BLK_W-1:0] {
        OH_MX = 3'd0,   // alignment bit (M) or alarm bit (X) in the last subframe
        OH_C1 = 3'd1,
        OH_F1 = 3'd2,
        OH_C2 = 3'd3,
        OH_C3 = 3'd4,
        OH_F2 = 3'd5    // followed by the stuff block
    } oh_slot_e;
endpackage

// File: rtl/m12_frame_pos.sv
module m12_frame_pos
    import m12_pkg::*;
#(
    parameter  int NUM_TRIB  = 4,
    parameter  int INFO_BITS = 48,
    localparam int BIT_W     = $clog2(INFO_BITS + 1),
    localparam int LANE_W    = $clog2(NUM_TRIB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [BIT_W-1:0]  slot,
    output logic [BLK_W-1:0]  blk,
    output logic [LANE_W-1:0] sf,
    output logic [LANE_W-1:0] lane
);
    typedef struct packed {
        logic [BIT_W-1:0]  slot;   // 0 = head bit, 1..INFO_BITS = information bits
        logic [BLK_W-1:0]  blk;
        logic [LANE_W-1:0] sf;
        logic [LANE_W-1:0] lane;   // tributary owning the current information bit
    } pos_t;

    pos_t pos_q, pos_d;

    always_comb begin
        pos_d = pos_q;
        if (adv) begin
            if (pos_q.slot == BIT_W'(INFO_BITS)) begin
                pos_d.slot = '0;
                pos_d.lane = '0;
                if (pos_q.blk == BLK_W'(BLOCKS_PER_SF - 1)) begin
                    pos_d.blk = '0;
                    pos_d.sf  = (pos_q.sf == LANE_W'(NUM_TRIB - 1)) ? '0 : pos_q.sf + 1'b1;
                end else begin
                    pos_d.blk = pos_q.blk + 1'b1;
                end
            end else begin
                pos_d.slot = pos_q.slot + 1'b1;
                if (pos_q.slot != '0) begin
                    pos_d.lane = (pos_q.lane == LANE_W'(NUM_TRIB - 1)) ? '0 : pos_q.lane + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign slot = pos_q.slot;
    assign blk  = pos_q.blk;
    assign sf   = pos_q.sf;
    assign lane = pos_q.lane;
endmodule

// File: rtl/m12_oh_gen.sv
module m12_oh_gen
    import m12_pkg::*;
(
    input  logic             [BLK_W-1:0] blk,
    input  logic             first_sf,
    input  logic             last_sf,
    input  logic             lof,
    input  logic             stuff_flag,
    input  logic             loop_flag,
    output logic             oh_bit
);
    always_comb begin
        case (oh_slot_e'(blk))
            OH_MX:   oh_bit = last_sf ? ~lof : ~first_sf;  // M pattern 0,1,1 then X
            OH_C1:   oh_bit = stuff_flag;
            OH_C2:   oh_bit = stuff_flag;
            OH_C3:   oh_bit = stuff_flag ^ loop_flag;      // loopback code flips C3
            OH_F1:   oh_bit = 1'b0;
            OH_F2:   oh_bit = 1'b1;
            default: oh_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/m12_lane_mux.sv
module m12_lane_mux #(
    parameter  int NUM_TRIB = 4,
    localparam int LANE_W   = $clog2(NUM_TRIB)
) (
    input  logic [LANE_W-1:0]   lane,
    input  logic                active,
    input  logic [NUM_TRIB-1:0] data,
    input  logic [NUM_TRIB-1:0] vld,
    output logic [NUM_TRIB-1:0] req,
    output logic                lane_bit
);
    logic [NUM_TRIB-1:0] inv_mask;

    for (genvar t = 0; t < NUM_TRIB; t++) begin : g_lane
        // even-numbered tributaries (2, 4, ...) travel inverted
        assign inv_mask[t] = 1'((t % 2) == 1);
        assign req[t]      = active && (lane == LANE_W'(t));
    end

    always_comb begin
        lane_bit = (vld[lane] ? data[lane] : 1'b1) ^ inv_mask[lane];
    end
endmodule

// File: rtl/m12_mux.sv
module m12_mux
    import m12_pkg::*;
#(
    parameter  int NUM_TRIB  = 4,
    parameter  int INFO_BITS = 48,
    localparam int BIT_W     = $clog2(INFO_BITS + 1),
    localparam int LANE_W    = $clog2(NUM_TRIB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                lof_in,
    input  logic [NUM_TRIB-1:0] stuff_req,
    input  logic [NUM_TRIB-1:0] loop_cmd,
    input  logic [NUM_TRIB-1:0] trib_data,
    input  logic [NUM_TRIB-1:0] trib_vld,
    output logic [NUM_TRIB-1:0] trib_req,
    output logic                t2_bit,
    output logic                t2_frame_start,
    output logic                t2_strobe
);
    typedef struct packed {
        logic [NUM_TRIB-1:0] stuff;   // stuff flag per tributary, held per subframe
        logic [NUM_TRIB-1:0] loopb;   // loopback flag per tributary
        logic                obit;
        logic                fs;
        logic                stb;
    } st_t;

    st_t st_q, st_d;

    logic [BIT_W-1:0]  slot;
    logic [BLK_W-1:0]  blk;
    logic [LANE_W-1:0] sf;
    logic [LANE_W-1:0] lane;
    logic              oh_bit;
    logic              lane_bit;
    logic              at_head;
    logic              sf_head;
    logic              stuff_slot;
    logic              info_take;

    m12_frame_pos #(.NUM_TRIB(NUM_TRIB), .INFO_BITS(INFO_BITS)) pos_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (bit_en),
        .slot  (slot),
        .blk   (blk),
        .sf    (sf),
        .lane  (lane)
    );

    m12_oh_gen oh_i (
        .blk        (blk),
        .first_sf   (sf == '0),
        .last_sf    (sf == LANE_W'(NUM_TRIB - 1)),
        .lof        (lof_in),
        .stuff_flag (st_q.stuff[sf]),
        .loop_flag  (st_q.loopb[sf]),
        .oh_bit     (oh_bit)
    );

    m12_lane_mux #(.NUM_TRIB(NUM_TRIB)) mux_i (
        .lane     (lane),
        .active   (info_take),
        .data     (trib_data),
        .vld      (trib_vld),
        .req      (trib_req),
        .lane_bit (lane_bit)
    );

    always_comb begin
        at_head    = (slot == '0);
        sf_head    = at_head && (blk == BLK_W'(OH_MX));
        // subframe n offers its stuff slot to tributary n in the first lane round of the last block
        stuff_slot = (blk == BLK_W'(OH_F2)) && !at_head &&
                     (slot <= BIT_W'(NUM_TRIB)) && (lane == sf) && st_q.stuff[sf];
        info_take  = bit_en && !at_head && !stuff_slot;

        st_d     = st_q;
        st_d.stb = bit_en;
        st_d.fs  = 1'b0;
        if (bit_en) begin
            if (sf_head) begin
                st_d.stuff[sf] = stuff_req[sf];
                st_d.loopb[sf] = loop_cmd[sf];
            end
            st_d.fs = sf_head && (sf == '0);
            if (at_head)         st_d.obit = oh_bit;
            else if (stuff_slot) st_d.obit = 1'b0;
            else                 st_d.obit = lane_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign t2_bit         = st_q.obit;
    assign t2_frame_start = st_q.fs;
    assign t2_strobe      = st_q.stb;
endmodule

// File: rtl/m12_mux_chk.sv
module m12_mux_chk #(
    parameter int NUM_TRIB  = 4,
    parameter int INFO_BITS = 48
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bit_en,
    input logic [NUM_TRIB-1:0] trib_req,
    input logic                t2_bit,
    input logic                t2_frame_start,
    input logic                t2_strobe
);
    localparam int FRAME_BITS = NUM_TRIB * 6 * (INFO_BITS + 1);
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    logic [CNT_W-1:0] stb_cnt;
    logic             seen_fs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_cnt <= '0;
            seen_fs <= 1'b0;
        end else if (t2_strobe) begin
            if (t2_frame_start) begin
                stb_cnt <= CNT_W'(1);
                seen_fs <= 1'b1;
            end else begin
                stb_cnt <= stb_cnt + 1'b1;
            end
        end
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trib_req)); // R4

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (|trib_req) |-> bit_en); // R11

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(t2_bit) && !t2_strobe)); // R11

    AST_FS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        t2_frame_start |-> t2_strobe); // R1

    AST_FS_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        t2_frame_start |-> !t2_bit); // R2

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (t2_strobe && t2_frame_start && seen_fs) |-> (stb_cnt == CNT_W'(FRAME_BITS))); // R1
endmodule

bind m12_mux m12_mux_chk #(.NUM_TRIB(NUM_TRIB), .INFO_BITS(INFO_BITS)) chk_i (.*);

// File: tb/m12_mux_tb.sv
`timescale 1ns/1ps
module m12_mux_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       lof_in = 1'b0;
    logic [3:0] stuff_req = '0;
    logic [3:0] loop_cmd = '0;
    logic [3:0] trib_data = '0;
    logic [3:0] trib_vld = '0;
    logic [3:0] trib_req;
    logic       t2_bit;
    logic       t2_frame_start;
    logic       t2_strobe;

    always #2.5 clk = ~clk;

    m12_mux dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_en         (bit_en),
        .lof_in         (lof_in),
        .stuff_req      (stuff_req),
        .loop_cmd       (loop_cmd),
        .trib_data      (trib_data),
        .trib_vld       (trib_vld),
        .trib_req       (trib_req),
        .t2_bit         (t2_bit),
        .t2_frame_start (t2_frame_start),
        .t2_strobe      (t2_strobe)
    );

    typedef struct {
        logic b;
        logic fs;
        int   tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   running  = 1'b0;
    bit   finished = 1'b0;
    logic last_bit = 1'b0;
    int   idle_ctr = 0;

    // per-frame plans, bit n-1 = subframe n
    logic [3:0] plan_st [4] = '{4'b0000, 4'b1111, 4'b0101, 4'b1010};
    logic [3:0] plan_lp [4] = '{4'b0000, 4'b0000, 4'b0110, 4'b0001};
    logic       plan_lof[4] = '{1'b0, 1'b0, 1'b1, 1'b0};
    logic       plan_gap[4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    logic       plan_inv[4] = '{1'b0, 1'b0, 1'b0, 1'b1};

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";   10: return "R10"; 11: return "R11"; default: return "R12";
        endcase
    endfunction

    task automatic check(bit ok, int tag, int act, int exp, string what);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag_name(tag), what, act, exp);
        end
    endtask

    // monitor: pops one expected bit for every strobe
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (t2_strobe) begin
                if (q.size() == 0) begin
                    check(1'b0, 11, 1, 0, "strobe with nothing expected");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(t2_bit == e.b, e.tag, int'(t2_bit), int'(e.b), "output bit");
                    check(t2_frame_start == e.fs, 1, int'(t2_frame_start), int'(e.fs), "frame start");
                end
                last_bit = t2_bit;
            end else begin
                check(t2_bit == last_bit, 11, int'(t2_bit), int'(last_bit), "hold while idle"); // R11
            end
        end
    end

    task automatic idle_cycle();
        bit_en    = 1'b0;
        trib_data = 4'($urandom);
        stuff_req = 4'($urandom);   // ignored: no bit is produced
        loop_cmd  = 4'($urandom);
        #1;
        check(trib_req == 4'b0, 11, int'(trib_req), 0, "request while idle");
        @(negedge clk);
    endtask

    task automatic drive_frame(int f);
        for (int sf = 0; sf < 4; sf++) begin
            for (int blk = 0; blk < 6; blk++) begin
                for (int b = 0; b <= 48; b++) begin
                    logic p_st, p_lp, start;
                    logic [3:0] exp_req;
                    exp_t e;
                    if (plan_gap[f]) begin
                        idle_ctr++;
                        if (idle_ctr % 7 == 3) idle_cycle();
                    end
                    p_st  = plan_st[f][sf];
                    p_lp  = plan_lp[f][sf];
                    start = (blk == 0) && (b == 0);
                    // R8: outside the subframe head the inputs carry the opposite value
                    stuff_req = start ? {4{p_st}} : {4{~p_st}};
                    loop_cmd  = start ? {4{p_lp}} : {4{~p_lp}};
                    lof_in    = plan_lof[f];
                    trib_data = 4'($urandom);
                    trib_vld  = (plan_inv[f] && (b % 5 == 0)) ? 4'b0000 : 4'b1111;
                    bit_en    = 1'b1;
                    exp_req   = 4'b0000;
                    e.fs      = (sf == 0) && start;
                    if (b == 0) begin
                        case (blk)
                            0: begin
                                if (sf == 3) begin e.b = ~plan_lof[f]; e.tag = 3; end
                                else begin e.b = (sf != 0); e.tag = 2; end
                            end
                            1: begin e.b = p_st; e.tag = 6; end
                            3: begin e.b = p_st; e.tag = 8; end
                            4: begin e.b = p_st ^ p_lp; e.tag = p_lp ? 9 : 6; end
                            2: begin e.b = 1'b0; e.tag = 2; end
                            default: begin e.b = 1'b1; e.tag = 2; end
                        endcase
                    end else begin
                        int lane;
                        lane = (b - 1) % 4;
                        if (blk == 5 && b <= 4 && lane == sf && p_st) begin
                            e.b = 1'b0; e.tag = 7;
                        end else begin
                            exp_req[lane] = 1'b1;
                            e.b   = (trib_vld[lane] ? trib_data[lane] : 1'b1) ^ (lane % 2 == 1);
                            e.tag = !trib_vld[lane] ? 10 : ((lane % 2 == 1) ? 5 : 4);
                        end
                    end
                    q.push_back(e);
                    #1;
                    check(trib_req == exp_req, (b == 0) ? 4 : e.tag, int'(trib_req), int'(exp_req), "request");
                    @(negedge clk);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(t2_bit == 1'b0, 12, int'(t2_bit), 0, "reset bit");
        check(t2_frame_start == 1'b0, 12, int'(t2_frame_start), 0, "reset frame start");
        check(t2_strobe == 1'b0, 12, int'(t2_strobe), 0, "reset strobe");
        check(trib_req == 4'b0, 12, int'(trib_req), 0, "reset request");
        rst_n   = 1'b1;
        running = 1'b1;
        @(negedge clk);
        for (int f = 0; f < 4; f++) drive_frame(f);
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        check(q.size() == 0, 1, q.size(), 0, "bits left unproduced");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R11 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule